// File: doc/BRIEF.md
# Synchronous Character Sync Detector

This block finds character alignment in a synchronous serial receive stream. The receive clock is presented as a one-cycle bit strobe, and one bit is taken per strobe. While hunting, the block shifts each new bit into a sliding window. It compares the window against one or two programmed sync characters. Once it finds a match, it switches to counting character boundaries and hands each assembled character to the downstream receiver.

A single bidirectional detect pin is split into an input, an output and an output enable. In internal-sync mode the block drives the pin and raises it when sync is found. In external-sync mode the block releases the pin and treats a high level on it as the command to start assembling characters. The detect flag also appears in a small status word. Reading that status word clears the flag. Three registers on a simple write port hold the mode, the first sync character and the second sync character. Writing the mode register restarts the hunt.

Top module: `syncdet_top`

## Requirements
- R1: After reset the detect pin is driven (`sync_pin_oe_o`=1) low, the detect status bit is 0 and the hunting bit is 1.
- R2: Serial input and the external pin are sampled only on clock edges where `bit_en_i` is high; with `bit_en_i` low, state and outputs hold.
- R3: In internal single-sync mode, the detect pin and status bit go high on the edge that samples the bit completing a window equal to sync character 1, checked on every bit while hunting; hunting then drops to 0.
- R4: Mode bits [1:0] = 0,1,2,3 set a character length of 5,6,7,8 bits; bits arrive LSB first and only the low L bits of a sync register take part in the comparison.
- R5: In internal double-sync mode (mode bit 2 = 0), detection needs sync character 1 followed immediately, at the next character boundary, by sync character 2; sync character 1 alone sets nothing, and a wrong second character returns to hunting.
- R6: A status read (`rd_status_i`) clears the detect flag, except that a detection on the same edge wins.
- R7: In external-sync mode (mode bit 3 = 1) the pin is not driven and sync matches are ignored; a high `sync_pin_i` on a bit strobe while hunting ends the hunt and sets the detect status bit, and that bit itself is not part of the data.
- R8: Once synchronized, every L-th sampled bit produces a one-cycle `char_valid_o` with the character on `char_o`, zero-extended and with the first received bit in bit 0.
- R9: In internal mode after synchronization, a character equal to sync character 1 at a boundary sets the detect flag again.
- R10: A write to the mode register (address 0) clears the detect flag, refills the window with ones and restarts the hunt. Address 1 holds sync character 1 and address 2 holds sync character 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mode, 1 sync 1, 2 sync 2 |
| wr_data_i | input | MAX_W | Write data; mode uses [3]=external, [2]=single, [1:0]=length code |
| rd_status_i | input | 1 | Status read strobe, clears detect |
| bit_en_i | input | 1 | One pulse per receive clock period |
| rx_bit_i | input | 1 | Serial receive data |
| sync_pin_i | input | 1 | Detect pin level when released (external sync) |
| sync_pin_o | output | 1 | Detect pin value when driven |
| sync_pin_oe_o | output | 1 | Detect pin output enable |
| status_o | output | 2 | [1] detect flag, [0] hunting |
| char_o | output | MAX_W | Last assembled character |
| char_valid_o | output | 1 | One-cycle pulse when `char_o` is new |

## Verification
The bench builds the block with its default maximum character length of 8. That makes every length code reachable, and it makes exhaustive sweeps practical. For each of the four lengths, every sync value except all-ones is hunted for, and a bench-side sliding window predicts on which bit detection must first occur. Directed sequences then cover double-sync success and failure, external start, boundary re-detection, a status read that coincides with a detection, and idle strobe gaps inside a character.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SECOND = 2'd1,
        ST_SYNCED = 2'd2
    } hunt_st_e;

    typedef struct packed {
        logic       ext;
        logic       single;
        logic [1:0] len;
    } mode_t;

    localparam int MODE_BITS = 4;

endpackage

// File: rtl/syncdet_cfg.sv
module syncdet_cfg
    import syncdet_pkg::*;
#(
    parameter int MAX_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [MAX_W-1:0] wr_data_i,
    output mode_t            mode_o,
    output logic [MAX_W-1:0] sync1_o,
    output logic [MAX_W-1:0] sync2_o,
    output logic             mode_wr_o
);

    typedef struct packed {
        mode_t            mode;
        logic [MAX_W-1:0] s1;
        logic [MAX_W-1:0] s2;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        mode_wr_o = 1'b0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                2'd0: begin
                    cfg_d.mode = mode_t'(wr_data_i[MODE_BITS-1:0]);
                    mode_wr_o  = 1'b1;
                end
                2'd1:    cfg_d.s1 = wr_data_i;
                2'd2:    cfg_d.s2 = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cfg_q <= '0;
        else       cfg_q <= cfg_d;
    end

    assign mode_o  = cfg_q.mode;
    assign sync1_o = cfg_q.s1;
    assign sync2_o = cfg_q.s2;

endmodule

// File: rtl/syncdet_window.sv
module syncdet_window #(
    parameter int MAX_W = 8,
    localparam int CW    = $clog2(MAX_W),
    localparam int MIN_W = MAX_W - 3
) (
    input  logic [MAX_W-1:0] shreg_i,
    input  logic             rx_bit_i,
    input  logic [1:0]       len_i,
    input  logic [MAX_W-1:0] sync1_i,
    input  logic [MAX_W-1:0] sync2_i,
    output logic [MAX_W-1:0] shreg_nx_o,
    output logic [MAX_W-1:0] win_o,
    output logic [CW-1:0]    last_idx_o,
    output logic             match1_o,
    output logic             match2_o
);

    int unsigned      char_len;
    logic [MAX_W-1:0] eq1, eq2;

    always_comb begin
        shreg_nx_o = {rx_bit_i, shreg_i[MAX_W-1:1]};
        char_len   = MIN_W + int'(len_i);
        win_o      = shreg_nx_o >> (MAX_W - char_len);
        last_idx_o = CW'(char_len - 1);
    end

    for (genvar i = 0; i < MAX_W; i++) begin : g_cmp
        assign eq1[i] = (i >= char_len) || (win_o[i] == sync1_i[i]);
        assign eq2[i] = (i >= char_len) || (win_o[i] == sync2_i[i]);
    end

    assign match1_o = &eq1;
    assign match2_o = &eq2;

endmodule

// File: rtl/syncdet_top.sv
module syncdet_top
    import syncdet_pkg::*;
#(
    parameter int MAX_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [MAX_W-1:0] wr_data_i,
    input  logic             rd_status_i,
    input  logic             bit_en_i,
    input  logic             rx_bit_i,
    input  logic             sync_pin_i,
    output logic             sync_pin_o,
    output logic             sync_pin_oe_o,
    output logic [1:0]       status_o,
    output logic [MAX_W-1:0] char_o,
    output logic             char_valid_o
);

    localparam int CW = $clog2(MAX_W);

    typedef struct packed {
        hunt_st_e         st;
        logic [MAX_W-1:0] shreg;
        logic [CW-1:0]    cnt;
        logic             det;
        logic [MAX_W-1:0] chr;
        logic             cval;
    } fsm_t;

    mode_t            mode;
    logic [MAX_W-1:0] sync1, sync2, shreg_nx, win;
    logic [CW-1:0]    last_idx;
    logic             mode_wr, match1, match2, det_set;
    fsm_t             st_d, st_q;

    syncdet_cfg #(.MAX_W(MAX_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mode_o    (mode),
        .sync1_o   (sync1),
        .sync2_o   (sync2),
        .mode_wr_o (mode_wr)
    );

    syncdet_window #(.MAX_W(MAX_W)) u_win (
        .shreg_i    (st_q.shreg),
        .rx_bit_i   (rx_bit_i),
        .len_i      (mode.len),
        .sync1_i    (sync1),
        .sync2_i    (sync2),
        .shreg_nx_o (shreg_nx),
        .win_o      (win),
        .last_idx_o (last_idx),
        .match1_o   (match1),
        .match2_o   (match2)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cval = 1'b0;
        det_set   = 1'b0;
        if (mode_wr) begin
            st_d.st    = ST_HUNT;
            st_d.cnt   = '0;
            st_d.shreg = '1;
            st_d.det   = 1'b0;
        end else begin
            if (bit_en_i) begin
                st_d.shreg = shreg_nx;
                unique case (st_q.st)
                    ST_HUNT: begin
                        if (mode.ext) begin
                            if (sync_pin_i) begin
                                st_d.st  = ST_SYNCED;
                                st_d.cnt = '0;
                                det_set  = 1'b1;
                            end
                        end else if (match1) begin
                            st_d.cnt = '0;
                            if (mode.single) begin
                                st_d.st = ST_SYNCED;
                                det_set = 1'b1;
                            end else begin
                                st_d.st = ST_SECOND;
                            end
                        end
                    end
                    ST_SECOND: begin
                        if (st_q.cnt == last_idx) begin
                            st_d.cnt = '0;
                            if (match2) begin
                                st_d.st = ST_SYNCED;
                                det_set = 1'b1;
                            end else if (!match1) begin
                                st_d.st = ST_HUNT;
                            end
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                    ST_SYNCED: begin
                        if (st_q.cnt == last_idx) begin
                            st_d.cnt  = '0;
                            st_d.cval = 1'b1;
                            st_d.chr  = win;
                            if (!mode.ext && match1) det_set = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                    default: st_d.st = ST_HUNT;
                endcase
            end
            st_d.det = det_set | (st_q.det & ~rd_status_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q       <= '0;
            st_q.st    <= ST_HUNT;
            st_q.shreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_pin_oe_o = ~mode.ext;
    assign sync_pin_o    = st_q.det & ~mode.ext;
    assign status_o      = {st_q.det, (st_q.st != ST_SYNCED)};
    assign char_o        = st_q.chr;
    assign char_valid_o  = st_q.cval;

endmodule

// File: rtl/syncdet_checker.sv
module syncdet_checker #(
    parameter int MAX_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic             rd_status_i,
    input logic             bit_en_i,
    input logic             sync_pin_o,
    input logic             sync_pin_oe_o,
    input logic [1:0]       status_o,
    input logic             char_valid_o
);

    logic mode_wr;
    assign mode_wr = wr_en_i && (wr_addr_i == 2'd0);

    a_r1_reset_state: assert property (@(posedge clk_i)
        rst_i |=> (sync_pin_oe_o && !sync_pin_o && status_o == 2'b01));

    a_r7_released_pin_low: assert property (@(posedge clk_i) disable iff (rst_i)
        !sync_pin_oe_o |-> !sync_pin_o);

    a_r6_detect_clear_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(status_o[1]) |-> ($past(rd_status_i) || $past(mode_wr)));

    a_r2_detect_on_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(status_o[1]) |-> $past(bit_en_i));

    a_r2_hunt_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!bit_en_i && !mode_wr) |-> $stable(status_o[0]));

    a_r8_char_when_synced: assert property (@(posedge clk_i) disable iff (rst_i)
        char_valid_o |-> ($past(bit_en_i) && !status_o[0]));

endmodule

bind syncdet_top syncdet_checker #(.MAX_W(MAX_W)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .rd_status_i   (rd_status_i),
    .bit_en_i      (bit_en_i),
    .sync_pin_o    (sync_pin_o),
    .sync_pin_oe_o (sync_pin_oe_o),
    .status_o      (status_o),
    .char_valid_o  (char_valid_o)
);

// File: tb/sim_syncdet_top.sv
module sim_syncdet_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0, rst = 1'b1;
    logic         wr_en = 1'b0, rd = 1'b0, bit_en = 1'b0, rx = 1'b1, pin_i = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pin_o, pin_oe, cval;
    logic [1:0]   status;
    logic [W-1:0] chr;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    syncdet_top #(.MAX_W(W)) u0 (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_status_i(rd), .bit_en_i(bit_en), .rx_bit_i(rx),
        .sync_pin_i(pin_i), .sync_pin_o(pin_o), .sync_pin_oe_o(pin_oe),
        .status_o(status), .char_o(chr), .char_valid_o(cval)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_stat();
        rd = 1'b1;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic p, input logic r);
        bit_en = 1'b1; rx = b; pin_i = p; rd = r;
        @(posedge clk); @(negedge clk);
        bit_en = 1'b0; pin_i = 1'b0; rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            rx = ~rx; pin_i = ~pin_i;
            @(posedge clk); @(negedge clk);
        end
        pin_i = 1'b0;
    endtask

    task automatic send_char(input logic [W-1:0] c, input int len);
        for (int i = 0; i < len; i++) send_bit(c[i], 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pin_oe == 1'b1 && pin_o == 1'b0, "R1 pin", {pin_oe, pin_o}, 2'b10);
        chk(status == 2'b01, "R1 status", status, 2'b01);

        // R3/R4: sweep every length and every detectable sync value, single internal mode
        for (int c = 0; c < 4; c++) begin
            int len = 5 + c;
            for (int s = 0; s < (1 << len) - 1; s++) begin
                logic [W-1:0] hist = '1;
                bit found = 0;
                wr(2'd1, W'(s));
                wr(2'd0, W'(4'b0100 | c));
                for (int i = 0; i < len && !found; i++) begin
                    logic [W-1:0] win;
                    hist = {W'(s >> i) & 1'b1, hist[W-1:1]} ;
                    win = hist >> (W - len);
                    found = (int'(win) == s);
                    send_bit(s[i], 1'b0, 1'b0);
                    chk(pin_o == found, "R3 R4 sweep pin", pin_o, found);
                    if (found) chk(status == 2'b10, "R3 status", status, 2'b10);
                end
                chk(found, "R4 sync found", found, 1);
                rd_stat();
                chk(pin_o == 1'b0, "R6 read clears", pin_o, 0);
            end
        end

        // R8/R2/R9/R6/R10: characters after sync, 8-bit single internal
        wr(2'd1, 8'h16);
        wr(2'd0, 8'h07);
        send_char(8'h16, 8);
        chk(pin_o == 1'b1, "R3 detect 8b", pin_o, 1);
        rd_stat();
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] d = 8'hA5;
            send_bit(d[i], 1'b0, 1'b0);
            chk(cval == (i == 7), "R8 valid timing", cval, i == 7);
            if (i == 7) chk(chr == 8'hA5, "R8 char", chr, 8'hA5);
            else begin
                idle(2);
                chk(cval == 1'b0 && status == 2'b00, "R2 idle gap", {cval, status}, 0);
            end
        end
        for (int i = 0; i < 7; i++) send_bit(1'(8'h16 >> i), 1'b0, 1'b0);
        chk(pin_o == 1'b0, "R9 before boundary", pin_o, 0);
        send_bit(1'b0, 1'b0, 1'b1);
        chk(pin_o == 1'b1, "R9 R6 redetect wins over read", pin_o, 1);
        chk(cval == 1'b1 && chr == 8'h16, "R8 sync as data", chr, 8'h16);
        wr(2'd0, 8'h07);
        chk(status == 2'b01, "R10 restart", status, 2'b01);

        // R5: double sync, 8-bit
        wr(2'd2, 8'h68);
        wr(2'd0, 8'h03);
        send_char(8'h16, 8);
        chk(status == 2'b01, "R5 first alone", status, 2'b01);
        send_char(8'h00, 8);
        chk(status == 2'b01, "R5 wrong second", status, 2'b01);
        send_char(8'hFF, 8);
        send_char(8'h16, 8);
        send_char(8'h68, 7);
        chk(status == 2'b01, "R5 before last bit", status, 2'b01);
        send_bit(1'b0, 1'b0, 1'b0);
        chk(status == 2'b10 && pin_o == 1'b1, "R5 pair detected", {status, pin_o}, 3'b101);

        // R7: external sync, 6-bit
        wr(2'd0, 8'h09);
        chk(pin_oe == 1'b0 && pin_o == 1'b0, "R7 released", {pin_oe, pin_o}, 0);
        send_char(8'h16, 6);
        chk(status == 2'b01, "R7 match ignored", status, 2'b01);
        idle(3);
        chk(status == 2'b01, "R2 pin without strobe", status, 2'b01);
        send_bit(1'b1, 1'b1, 1'b0);
        chk(status == 2'b10, "R7 pin start", status, 2'b10);
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] d = 8'h2B;
            send_bit(d[i], 1'b0, 1'b0);
            chk(cval == (i == 5), "R7 R8 ext valid", cval, i == 5);
        end
        chk(chr == 8'h2B, "R7 ext char", chr, 8'h2B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule